// File: doc/BRIEF.md
# PDM Microphone Sample-Point Capture

This block turns up to eight pulse-density-modulated microphone streams into single-bit samples. It regenerates the PDM bit clock from a fast system clock by counting a programmable number of system cycles per half period and toggling the clock output at the end of each count. Microphone pairs share a data line: one talks while the bit clock is high, the other while it is low. Each channel therefore samples its line once per bit-clock period, at one system-clock count chosen by software inside its own half period, rather than on a clock edge. This lets the capture instant be placed late in the half period, after the microphone output has settled and the board delay has elapsed.

The configuration inputs are plain level signals held by a register file elsewhere: a global run bit, per-channel enable and active-low reset masks, two 32-bit words of packed 8-bit sample pointers, and the half-period length. Each sampled bit is presented on its own output, together with a one-cycle valid strobe, to a decimation filter downstream.

Top module: `pdm_capture`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the bit clock output, all sample bits and all valid strobes are 0.
- R2: With the global run bit set, the bit clock output holds each level for L system cycles, where L is the half-period length input (a value of 0 acts as 1); with the run bit clear, the bit clock stays low and the half-period count is held at 0.
- R3: A channel whose pointer P satisfies P < L-1 raises its valid strobe exactly P+1 system cycles after the bit-clock transition that opens its half period (the counter runs 0 to L-1 inside each half period, and the match cycle is registered once).
- R4: Channel c (c = 0..3) takes its pointer from bits [8c+7:8c] of the low pointer word; channel c (c = 4..7) from bits [8(c-4)+7:8(c-4)] of the high pointer word.
- R5: Channel c reads data line c/2 (integer division); even channels capture during the high half period of the bit clock, odd channels during the low half period.
- R6: A channel captures only when its enable bit is 1 and its active-low reset bit is 1; while its reset bit is 0, its sample bit and valid strobe are forced to 0.
- R7: With the global run bit clear, no channel produces a valid strobe, whatever the channel masks and pointers.
- R8: The data lines pass through two register stages before sampling; the captured bit equals the data line value held steady across the half period.
- R9: Each valid strobe is high for a single system cycle per capture, and the sample bit keeps its value until the channel's next capture.
- R10: A channel whose pointer is L or greater never produces a valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| cfg_run | input | 1 | Global run bit: starts the bit clock and allows capture |
| cfg_chan_en | input | 8 | Per-channel capture enable |
| cfg_chan_rstn | input | 8 | Per-channel active-low reset |
| cfg_ptr_lo | input | 32 | Packed 8-bit pointers of channels 0 to 3 |
| cfg_ptr_hi | input | 32 | Packed 8-bit pointers of channels 4 to 7 |
| cfg_half_len | input | 8 | System cycles per half period of the bit clock |
| pdm_clk_o | output | 1 | Regenerated PDM bit clock to the microphones |
| pdm_data_i | input | 4 | Shared microphone data lines |
| smp_bit_o | output | 8 | Last captured bit of each channel |
| smp_valid_o | output | 8 | One-cycle strobe per channel on each capture |

## Verification
The hardest situation to reach is a data line carrying different values in the two halves of one bit-clock period, since only then does the pairing of even channels with the high half and odd channels with the low half show. The bench reaches it with a task that watches the bit clock output every cycle and drives all lines high while it is high and low while it is low; with every pointer placed past the two-stage synchronizer delay, each even channel must capture 1 and each odd channel 0. Pointer placement is checked by measuring, from the outside, the distance between each bit-clock transition and each strobe.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
   localparam int PTR_W         = 8;
   localparam int WORD_W        = 32;
   localparam int PTRS_PER_WORD = WORD_W / PTR_W;
   localparam int MAX_CHANS     = 2 * PTRS_PER_WORD;

   typedef logic [PTR_W-1:0] ptr_t;

   // last count value of a half period; a zero length behaves as one
   function automatic ptr_t last_count(input ptr_t half_len);
      return (half_len == '0) ? '0 : half_len - 1'b1;
   endfunction
endpackage

// File: rtl/pdm_halfper_gen.sv
module pdm_halfper_gen
   import pdm_cap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  ptr_t half_len,
   output ptr_t cnt,
   output logic phase
);
   ptr_t cnt_q;
   logic phase_q;
   ptr_t last;

   assign last = last_count(half_len);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (cnt_q >= last) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign cnt   = cnt_q;
   assign phase = phase_q;
endmodule

// File: rtl/pdm_line_sync.sv
module pdm_line_sync #(
   parameter int LINES  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pdm_line_sync: STAGES must be at least 2");
   end

   logic [LINES-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)
            stg_q[s] <= '0;
         else if (s == 0)
            stg_q[s] <= din;
         else
            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pdm_chan_slot.sv
module pdm_chan_slot
   import pdm_cap_pkg::*;
#(
   parameter bit HIGH_HALF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic allow,
   input  logic chan_rstn,
   input  ptr_t ptr,
   input  ptr_t cnt,
   input  logic phase,
   input  logic line_bit,
   output logic bit_o,
   output logic valid_o
);
   logic hit;
   logic bit_q, valid_q;

   assign hit = allow && (cnt == ptr) && (phase == HIGH_HALF);

   always_ff @(posedge clk) begin
      if (!rst_n || !chan_rstn) begin
         bit_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= hit;
         if (hit)
            bit_q <= line_bit;
      end
   end

   assign bit_o   = bit_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
   import pdm_cap_pkg::*;
#(
   parameter int CHANS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_run,
   input  logic [CHANS-1:0] cfg_chan_en,
   input  logic [CHANS-1:0] cfg_chan_rstn,
   input  logic [WORD_W-1:0] cfg_ptr_lo,
   input  logic [WORD_W-1:0] cfg_ptr_hi,
   input  logic [PTR_W-1:0] cfg_half_len,
   output logic             pdm_clk_o,
   input  logic [(CHANS+1)/2-1:0] pdm_data_i,
   output logic [CHANS-1:0] smp_bit_o,
   output logic [CHANS-1:0] smp_valid_o
);
   localparam int LINES = (CHANS + 1) / 2;

   if (CHANS < 1 || CHANS > MAX_CHANS) begin : g_bad_chans
      $error("pdm_capture: CHANS must be 1..%0d", MAX_CHANS);
   end

   ptr_t             half_cnt;
   logic             phase;
   logic [LINES-1:0] line_sync;

   pdm_halfper_gen u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (cfg_run),
      .half_len (cfg_half_len),
      .cnt      (half_cnt),
      .phase    (phase)
   );

   pdm_line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pdm_data_i),
      .dout  (line_sync)
   );

   for (genvar c = 0; c < CHANS; c++) begin : g_chan
      ptr_t ptr;
      // R4: pointer packing, four per word
      if (c < PTRS_PER_WORD) begin : g_lo
         assign ptr = cfg_ptr_lo[(c % PTRS_PER_WORD)*PTR_W +: PTR_W];
      end else begin : g_hi
         assign ptr = cfg_ptr_hi[(c % PTRS_PER_WORD)*PTR_W +: PTR_W];
      end

      pdm_chan_slot #(.HIGH_HALF((c % 2) == 0)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .allow     (cfg_run & cfg_chan_en[c] & cfg_chan_rstn[c]),
         .chan_rstn (cfg_chan_rstn[c]),
         .ptr       (ptr),
         .cnt       (half_cnt),
         .phase     (phase),
         .line_bit  (line_sync[c/2]),
         .bit_o     (smp_bit_o[c]),
         .valid_o   (smp_valid_o[c])
      );
   end

   assign pdm_clk_o = phase;
endmodule

// File: rtl/pdm_capture_checker.sv
module pdm_capture_checker
   import pdm_cap_pkg::*;
#(
   parameter int CHANS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_run,
   input logic [CHANS-1:0] cfg_chan_en,
   input logic [CHANS-1:0] cfg_chan_rstn,
   input logic [PTR_W-1:0] cfg_half_len,
   input logic [PTR_W-1:0] half_cnt,
   input logic             pdm_clk_o,
   input logic [CHANS-1:0] smp_bit_o,
   input logic [CHANS-1:0] smp_valid_o
);
   AST_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_run |=> (!pdm_clk_o && half_cnt == '0)); // R2

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_run) |-> (half_cnt == '0 || half_cnt < $past(cfg_half_len))); // R2

   AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_run) |-> (smp_valid_o == '0)); // R7

   AST_CHAN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_o & ~($past(cfg_chan_en) & $past(cfg_chan_rstn))) == '0); // R6

   AST_RSTN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_bit_o & ~$past(cfg_chan_rstn)) == '0); // R6

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_o & $past(smp_valid_o)) == '0); // R9

   for (genvar c = 0; c < CHANS; c++) begin : g_half
      if ((c % 2) == 0) begin : g_even
         AST_EVEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            smp_valid_o[c] |-> $past(pdm_clk_o)); // R5
      end else begin : g_odd
         AST_ODD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            smp_valid_o[c] |-> !$past(pdm_clk_o)); // R5
      end
   end
endmodule

bind pdm_capture pdm_capture_checker #(.CHANS(CHANS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_run       (cfg_run),
   .cfg_chan_en   (cfg_chan_en),
   .cfg_chan_rstn (cfg_chan_rstn),
   .cfg_half_len  (cfg_half_len),
   .half_cnt      (half_cnt),
   .pdm_clk_o     (pdm_clk_o),
   .smp_bit_o     (smp_bit_o),
   .smp_valid_o   (smp_valid_o)
);

// File: tb/pdm_capture_test.sv
module pdm_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_run = 1'b0;
   logic [7:0]  cfg_chan_en = '0;
   logic [7:0]  cfg_chan_rstn = '0;
   logic [31:0] cfg_ptr_lo = '0;
   logic [31:0] cfg_ptr_hi = '0;
   logic [7:0]  cfg_half_len = 8'd10;
   logic [3:0]  pdm_data_i = '0;
   logic        pdm_clk_o;
   logic [7:0]  smp_bit_o;
   logic [7:0]  smp_valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pdm_capture uut (
      .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_chan_en(cfg_chan_en),
      .cfg_chan_rstn(cfg_chan_rstn), .cfg_ptr_lo(cfg_ptr_lo), .cfg_ptr_hi(cfg_ptr_hi),
      .cfg_half_len(cfg_half_len), .pdm_clk_o(pdm_clk_o), .pdm_data_i(pdm_data_i),
      .smp_bit_o(smp_bit_o), .smp_valid_o(smp_valid_o)
   );

   // port monitor, sampled away from the active edge
   int  since = 0, hi_run = 0, lo_run = 0, toggles = 0;
   bit  prev_clk = 1'b0;
   int  vcount [8];
   int  vdelay [8];
   bit  vphase [8];
   bit  vbit   [8];
   int  vstreak[8];
   int  vmax   [8];

   initial begin
      for (int c = 0; c < 8; c++) begin
         vcount[c] = 0; vdelay[c] = -1; vphase[c] = 0; vbit[c] = 0;
         vstreak[c] = 0; vmax[c] = 0;
      end
   end

   always @(negedge clk) begin
      if (pdm_clk_o != prev_clk) begin
         if (prev_clk) hi_run = since + 1; else lo_run = since + 1;
         since = 0;
         toggles++;
      end else begin
         since++;
      end
      prev_clk = pdm_clk_o;
      for (int c = 0; c < 8; c++) begin
         if (smp_valid_o[c]) begin
            vcount[c]++;
            vdelay[c]  = since;
            vphase[c]  = pdm_clk_o;
            vbit[c]    = smp_bit_o[c];
            vstreak[c]++;
            if (vstreak[c] > vmax[c]) vmax[c] = vstreak[c];
         end else begin
            vstreak[c] = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int ptr_of(input int c);
      return (c < 4) ? int'(cfg_ptr_lo[c*8 +: 8]) : int'(cfg_ptr_hi[(c-4)*8 +: 8]);
   endfunction

   task automatic t_reset();
      wait_cyc(3);
      check(pdm_clk_o == 1'b0, "R1 clk in reset", pdm_clk_o, 0);
      check(smp_valid_o == '0, "R1 valid in reset", smp_valid_o, 0);
      check(smp_bit_o == '0, "R1 bits in reset", smp_bit_o, 0);
      rst_n = 1'b1;
      wait_cyc(1);
      check(smp_valid_o == '0 && pdm_clk_o == 1'b0, "R1 after release", smp_valid_o, 0);
   endtask

   task automatic t_clock(input int len);
      cfg_run = 1'b0;
      cfg_half_len = 8'(len);
      wait_cyc(2);
      cfg_run = 1'b1;
      wait_cyc(8 * len + 4);
      check(hi_run == len, "R2 high length", hi_run, len);
      check(lo_run == len, "R2 low length", lo_run, len);
   endtask

   task automatic t_capture(input logic [3:0] pattern);
      int base [8];
      pdm_data_i = pattern;
      wait_cyc(24);
      for (int c = 0; c < 8; c++) base[c] = vcount[c];
      wait_cyc(100);
      for (int c = 0; c < 8; c++) begin
         check(vcount[c] - base[c] >= 4, "R3 strobes seen", vcount[c] - base[c], 4);
         check(vdelay[c] == ptr_of(c) + 1, "R3 R4 strobe position", vdelay[c], ptr_of(c) + 1);
         check(vphase[c] == ((c % 2) == 0), "R5 half period", vphase[c], (c % 2) == 0);
         check(vbit[c] == pattern[c/2], "R8 captured bit", vbit[c], pattern[c/2]);
         check(vmax[c] == 1, "R9 strobe width", vmax[c], 1);
      end
      wait_cyc(3);
      for (int c = 0; c < 8; c++)
         if (!smp_valid_o[c])
            check(smp_bit_o[c] == pattern[c/2], "R9 bit held", smp_bit_o[c], pattern[c/2]);
   endtask

   task automatic t_split();
      int base [8];
      cfg_ptr_lo = {4{8'd5}};
      cfg_ptr_hi = {4{8'd5}};
      for (int c = 0; c < 8; c++) base[c] = vcount[c];
      for (int i = 0; i < 160; i++) begin
         @(negedge clk);
         pdm_data_i = pdm_clk_o ? 4'hF : 4'h0;
      end
      for (int c = 0; c < 8; c++) begin
         check(vcount[c] > base[c], "R5 split strobes", vcount[c] - base[c], 1);
         check(vbit[c] == ((c % 2) == 0), "R5 split value", vbit[c], (c % 2) == 0);
      end
   endtask

   task automatic t_chan_gate();
      int base [8];
      pdm_data_i = 4'hF;
      wait_cyc(40);
      cfg_chan_en   = 8'b1111_1001;
      cfg_chan_rstn = 8'b1111_0111;
      wait_cyc(2);
      for (int c = 0; c < 8; c++) base[c] = vcount[c];
      wait_cyc(80);
      check(vcount[1] == base[1], "R6 disabled ch1", vcount[1] - base[1], 0);
      check(vcount[2] == base[2], "R6 disabled ch2", vcount[2] - base[2], 0);
      check(vcount[3] == base[3], "R6 reset ch3", vcount[3] - base[3], 0);
      check(smp_bit_o[3] == 1'b0, "R6 reset clears bit", smp_bit_o[3], 0);
      check(vcount[0] > base[0], "R6 enabled ch0", vcount[0] - base[0], 1);
      cfg_chan_en = 8'hFF;
      cfg_chan_rstn = 8'hFF;
   endtask

   task automatic t_global();
      int base [8];
      int tg;
      cfg_run = 1'b0;
      wait_cyc(2);
      for (int c = 0; c < 8; c++) base[c] = vcount[c];
      tg = toggles;
      wait_cyc(60);
      check(toggles == tg, "R2 idle clock", toggles - tg, 0);
      check(pdm_clk_o == 1'b0, "R2 idle level", pdm_clk_o, 0);
      for (int c = 0; c < 8; c++)
         check(vcount[c] == base[c], "R7 no strobes when stopped", vcount[c] - base[c], 0);
   endtask

   task automatic t_ptr_range();
      int base [8];
      cfg_half_len = 8'd6;
      cfg_ptr_lo = {8'd3, 8'd0, 8'd200, 8'd6};
      cfg_ptr_hi = {8'd1, 8'd2, 8'd3, 8'd4};
      cfg_run = 1'b1;
      wait_cyc(4);
      for (int c = 0; c < 8; c++) base[c] = vcount[c];
      wait_cyc(72);
      check(vcount[0] == base[0], "R10 pointer equal to length", vcount[0] - base[0], 0);
      check(vcount[1] == base[1], "R10 pointer far beyond", vcount[1] - base[1], 0);
      check(vcount[2] > base[2], "R3 pointer zero strobes", vcount[2] - base[2], 1);
      check(vdelay[2] == 1, "R3 pointer zero position", vdelay[2], 1);
      check(vdelay[7] == 2, "R4 high word top lane", vdelay[7], 2);
   endtask

   initial begin
      fork
         begin
            cfg_chan_en   = 8'hFF;
            cfg_chan_rstn = 8'hFF;
            cfg_ptr_lo    = {8'd4, 8'd3, 8'd2, 8'd1};
            cfg_ptr_hi    = {8'd8, 8'd7, 8'd6, 8'd5};
            t_reset();
            t_clock(3);
            t_clock(10);
            t_capture(4'b0101);
            t_capture(4'b1010);
            t_split();
            t_chan_gate();
            t_global();
            t_ptr_range();
            done = 1'b1;
         end
         begin
            repeat (100000) @(posedge clk);
            if (!done) begin
               checks++;
               errors++;
               $display("FAIL watchdog: actual 0 expected 1");
            end
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule